// File: doc/BRIEF.md
# Modulo-3 Running-Sum Accumulator

This block keeps a running total of a stream of 2-bit operands, reduced modulo 3. On every rising clock edge the operand presented on `opnd` is added to the stored total, and the remainder after division by 3 becomes the new total. The total is held in a 2-bit register. That register drives the output directly, so the output is a pure function of state and moves only at clock edges.

The operand code `2'b11` is taken to mean "add three". Modulo 3 this leaves the total unchanged. The register code `2'b11` cannot be reached in normal operation. If the register ever held it, the next edge would force the register to zero. Reset is synchronous and active high.

Top module: `m3_accumulator`

## Requirements
- R1: When `rst` is high at a rising clock edge, `sum_o` is `2'b00` after that edge, whatever the value on `opnd`.
- R2: When `rst` is low at a rising clock edge, `sum_o` after the edge equals (value of `sum_o` before the edge + value of `opnd`) mod 3, where `opnd` is read as an unsigned number from 0 to 3.
- R3: `sum_o` changes only at rising clock edges. A change on `opnd` between edges has no effect on `sum_o` until the next edge.
- R4: The total is encoded on `sum_o` as 0 = `2'b00`, 1 = `2'b01` and 2 = `2'b10`. The code `2'b11` never appears on `sum_o` once a reset has been applied.
- R5: With a total of 2 and an operand of 2 (`2'b10`), the next total is 1 (`2'b01`).
- R6: An operand of `2'b11` leaves `sum_o` unchanged across the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; clears the total |
| opnd | input | 2 | Operand added to the total at each edge |
| sum_o | output | 2 | Stored total, taken straight from the state register |

## Verification
The bench aims at the point where the total wraps. A design that reduced modulo 4 instead of modulo 3 would show 0 after 2+2 rather than 1, and it would let the code `2'b11` reach the output. Operand `2'b11` is driven from each of the three totals. A design that treated it as a don't-care would jump to an arbitrary total instead of holding. The bench also changes the operand between clock edges and applies reset with a non-zero operand present. Either test shows up a design that lets the output follow the input combinationally, or one that lets the operand win over reset.

// File: rtl/m3_acc_pkg.sv
package m3_acc_pkg;

    localparam int SUM_W = 2;
    localparam int OPND_W = 2;
    localparam int MODULUS = 3;

    typedef enum logic [SUM_W-1:0] {
        TOT_ZERO = 2'b00,
        TOT_ONE  = 2'b01,
        TOT_TWO  = 2'b10,
        TOT_BAD  = 2'b11
    } total_e;

    typedef enum logic [1:0] {
        INC_NONE = 2'b00,
        INC_ONE  = 2'b01,
        INC_TWO  = 2'b10
    } incr_e;

    typedef struct packed {
        total_e cur;
        incr_e  inc;
    } step_t;

    // Advance a legal total by one step of size one.
    function automatic total_e bump(input total_e t);
        case (t)
            TOT_ZERO: bump = TOT_ONE;
            TOT_ONE:  bump = TOT_TWO;
            default:  bump = TOT_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/m3_operand_map.sv
module m3_operand_map
    import m3_acc_pkg::*;
(
    input  logic [OPND_W-1:0] raw,
    output incr_e             inc
);
    // An operand of three is a whole turn of the modulus: no net step.
    always_comb begin
        case (raw)
            2'b01:   inc = INC_ONE;
            2'b10:   inc = INC_TWO;
            default: inc = INC_NONE;
        endcase
    end

    // R6: the full-turn code must collapse to a zero step
    always_comb begin
        a_r6_full_turn_zero: assert (!(raw === 2'b11) || inc === INC_NONE);
    end
endmodule

// File: rtl/m3_next_state.sv
module m3_next_state
    import m3_acc_pkg::*;
(
    input  step_t  step,
    output total_e nxt
);
    always_comb begin
        if (step.cur == TOT_BAD) begin
            nxt = TOT_ZERO;
        end else begin
            case (step.inc)
                INC_ONE: nxt = bump(step.cur);
                INC_TWO: nxt = bump(bump(step.cur));
                default: nxt = step.cur;
            endcase
        end
    end

    // R4: the next-state logic never produces the unused code
    always_comb begin
        a_r4_no_bad_next: assert (!(nxt === TOT_BAD));
    end
endmodule

// File: rtl/m3_state_reg.sv
module m3_state_reg
    import m3_acc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  total_e d,
    output total_e q
);
    always_ff @(posedge clk) begin
        if (rst) q <= TOT_ZERO;
        else     q <= d;
    end

    // R1: reset clears the register at the next edge
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> q == TOT_ZERO);
    // R4: the register never holds the unused code outside reset
    a_r4_legal_code: assert property (@(posedge clk) disable iff (rst) q != TOT_BAD);
endmodule

// File: rtl/m3_accumulator.sv
module m3_accumulator
    import m3_acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OPND_W-1:0] opnd,
    output logic [SUM_W-1:0]  sum_o
);
    incr_e  inc;
    total_e nxt;
    total_e cur;
    step_t  step;

    m3_operand_map u_map (
        .raw (opnd),
        .inc (inc)
    );

    assign step = '{cur: cur, inc: inc};

    m3_next_state u_next (
        .step (step),
        .nxt  (nxt)
    );

    m3_state_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (nxt),
        .q   (cur)
    );

    assign sum_o = cur;

    // R2: each edge adds the operand, reduced modulo three
    a_r2_mod_step: assert property (@(posedge clk) disable iff (rst)
        !rst |=> int'(sum_o) == (int'($past(sum_o)) + int'($past(opnd))) % MODULUS);
    // R5: the wrap point, two plus two
    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        (sum_o == 2'b10 && opnd == 2'b10) |=> sum_o == 2'b01);
    // R6: an operand of three holds the total
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        opnd == 2'b11 |=> $stable(sum_o));
endmodule

// File: tb/sim_m3_accumulator.sv
module sim_m3_accumulator;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] opnd = 2'b00;
    logic [1:0] sum_o;

    int n_run  = 0;
    int n_fail = 0;
    int model  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    m3_accumulator u0 (
        .clk   (clk),
        .rst   (rst),
        .opnd  (opnd),
        .sum_o (sum_o)
    );

    task automatic check(input string req, input int exp);
        n_run++;
        if (int'(sum_o) != exp || $isunknown(sum_o)) begin
            n_fail++;
            $display("FAIL %s: sum_o=%0d expected %0d at %0t", req, sum_o, exp, $time);
        end
    endtask

    // Drive at the falling edge, sample one unit after the rising edge.
    task automatic step(input logic r, input logic [1:0] x, input string req);
        @(negedge clk);
        rst  = r;
        opnd = x;
        @(posedge clk);
        #1;
        if (r) model = 0;
        else   model = (model + int'(x)) % 3;
        check(req, model);
    endtask

    initial begin
        step(1'b1, 2'b00, "R1 reset state");
        step(1'b1, 2'b10, "R1 reset with operand present");
        step(1'b0, 2'b01, "R2 0+1");
        step(1'b0, 2'b01, "R2 1+1");
        step(1'b0, 2'b10, "R5 2+2 wraps to 1");
        step(1'b0, 2'b10, "R2 1+2 wraps to 0");
        step(1'b0, 2'b11, "R6 hold at 0");
        step(1'b0, 2'b01, "R2 0+1");
        step(1'b0, 2'b11, "R6 hold at 1");
        step(1'b0, 2'b01, "R2 1+1");
        step(1'b0, 2'b11, "R6 hold at 2");
        step(1'b0, 2'b00, "R2 add zero");
        // R3: a mid-cycle operand change must not move the output
        @(negedge clk);
        opnd = 2'b01;
        #1;
        check("R3 no change between edges", model);
        opnd = 2'b10;
        #1;
        check("R3 no change between edges", model);
        @(posedge clk);
        #1;
        model = (model + 2) % 3;
        check("R2 value taken at edge", model);
        step(1'b1, 2'b01, "R1 reset dominates operand");
        for (int i = 0; i < 400; i++) begin
            logic [1:0] x;
            x = 2'($urandom_range(0, 3));
            step(1'b0, x, "R2 random operand");
            n_run++;
            if (sum_o == 2'b11) begin
                n_fail++;
                $display("FAIL R4: sum_o=3 expected 0..2");
            end
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule